// File: doc/BRIEF.md
# Sequenced Breakpoint Trigger Unit

This unit sits beside an emulated 8-bit processor and inspects every bus cycle. Each valid cycle forms a 32-bit compare word from the address, the CPU status byte and the user hardware status byte. Two compare units test this word against programmed values under per-bit care masks. A selected trigger mode combines the two hit results. Two of the modes depend on the order of the hits.

Once the trigger is met, the unit can halt at once. It can instead coast: it counts a chosen kind of later event (register hits, memory cycles, I/O cycles) up to a programmed count n, and then raises a halt request. The halt request is a level that stays high until software clears it. Both compare hits are also exported as one-cycle pulses for use by other logic.

Top module: `brk_trigger_top`

## Requirements
- R1: The compare word is {busAddr, cpuStat, userStat}, with the address in bits 31:16, the CPU status in bits 15:8 and the user status in bits 7:0. Register writes with cfgAddr 0, 1, 2 and 3 load the value of compare unit A, the care mask of A, the value of B and the care mask of B. A unit matches when every bit whose care bit is 1 equals the stored value bit. A care bit of 0 means don't care.
- R2: hitA and hitB are high for exactly the cycle after a cycle in which busValid is high and the respective unit matches. A cycle with busValid low never produces a hit.
- R3: A write with cfgAddr 4 loads the trigger setup. Bits 2:0 are the mode, bits 6:4 are the coast kind and bits 15:8 are n. Mode codes: 0 = A, 1 = B, 2 = A or B, 3 = A after B, 4 = B after A. Modes 5 to 7 never trigger, and mode 7 is the value after reset.
- R4: In modes 0, 1 and 2 with no coast, a valid cycle that meets the mode sets haltReq in the following cycle.
- R5: In modes 3 and 4, a hit of the first-named unit's partner arms the unit: B arms mode 3 and A arms mode 4. A later hit of the other unit then triggers. A cycle in which both units hit only arms, and does not trigger.
- R6: Coast kind codes: 1 = A hits, 2 = B hits, 3 = A or B hits, 4 = valid memory cycles, 5 = valid I/O cycles, 6 = valid memory or I/O cycles. After the trigger cycle, haltReq rises the cycle after the n-th such event. The trigger cycle itself is not counted.
- R7: Coast kind 0 or 7, or n = 0, halts immediately on the trigger, as in R4.
- R8: haltReq stays high until haltClr is pulsed. haltClr drops it the next cycle, returns the unit to watching and clears the armed state. Bus cycles seen while halted do not re-trigger, though the hits still pulse.
- R9: A register write clears the armed state and abandons a coast in progress. The write suppresses trigger evaluation in its own cycle. It does not change haltReq.
- R10: After reset, haltReq, hitA and hitB are low, all compare values and masks are zero, and the mode is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register select |
| cfgData | input | 32 | Register write data |
| busValid | input | 1 | Bus cycle valid strobe |
| busAddr | input | 16 | Bus address |
| cpuStat | input | 8 | Target CPU status byte |
| userStat | input | 8 | User hardware status byte |
| isMem | input | 1 | Cycle is a memory read/write |
| isIo | input | 1 | Cycle is an I/O read/write |
| haltClr | input | 1 | Clears the halt request |
| hitA | output | 1 | Compare unit A hit pulse |
| hitB | output | 1 | Compare unit B hit pulse |
| haltReq | output | 1 | Halt request level |

## Verification
Arming and triggering can fall in the same cycle in the ordered modes, when one bus word satisfies both compare units. The bench builds such a word on purpose, with A keyed on the address and B keyed on the CPU status. It then checks that this cycle only arms, and that a later single hit produces the halt. A register write can also land on the cycle that would trigger or end a coast. The bench drives both in one cycle and expects hits to pulse while haltReq stays low.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {ST_WATCH, ST_COAST, ST_HALT} trigState_t;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
  } ctlStrobe_t;

  localparam logic [2:0] MODE_A       = 3'd0;
  localparam logic [2:0] MODE_B       = 3'd1;
  localparam logic [2:0] MODE_EITHER  = 3'd2;
  localparam logic [2:0] MODE_A_AFT_B = 3'd3;
  localparam logic [2:0] MODE_B_AFT_A = 3'd4;
  localparam logic [2:0] MODE_OFF     = 3'd7;

  localparam logic [2:0] COAST_HIT_A  = 3'd1;
  localparam logic [2:0] COAST_HIT_B  = 3'd2;
  localparam logic [2:0] COAST_HIT_AB = 3'd3;
  localparam logic [2:0] COAST_MEM    = 3'd4;
  localparam logic [2:0] COAST_IO     = 3'd5;
  localparam logic [2:0] COAST_MEMIO  = 3'd6;

  localparam logic [2:0] REG_CTRL = 3'd4;
endpackage

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STAT_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfgWrEn,
  input  logic [2:0]                   cfgAddr,
  input  logic [ADDR_W+2*STAT_W-1:0]   cfgData,
  input  logic                         busValid,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [STAT_W-1:0]            cpuStat,
  input  logic [STAT_W-1:0]            userStat,
  input  logic                         isMem,
  input  logic                         isIo,
  input  ctlStrobe_t                   strobe,
  output logic                         matchA,
  output logic                         matchB,
  output logic                         coastEv,
  output logic                         coastOn,
  output logic                         cntLast,
  output logic [2:0]                   modeSel,
  output logic                         hitA,
  output logic                         hitB
);
  localparam int WORD_W  = ADDR_W + 2 * STAT_W;
  localparam int N_UNITS = 2;
  localparam int CNT_LSB = 8;

  logic [N_UNITS-1:0][WORD_W-1:0] cmpVal;
  logic [N_UNITS-1:0][WORD_W-1:0] cmpCare;
  logic [N_UNITS-1:0]             unitMatch;
  logic [WORD_W-1:0]              busWord;
  logic [2:0]                     coastSel;
  logic [CNT_W-1:0]               coastN;
  logic [CNT_W-1:0]               cnt;

  assign busWord = {busAddr, cpuStat, userStat};

  for (genvar gi = 0; gi < N_UNITS; gi++) begin : g_unit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmpVal[gi]  <= '0;
        cmpCare[gi] <= '0;
      end else if (cfgWrEn) begin
        if (cfgAddr == 3'(2 * gi))     cmpVal[gi]  <= cfgData;
        if (cfgAddr == 3'(2 * gi + 1)) cmpCare[gi] <= cfgData;
      end
    end
    assign unitMatch[gi] = busValid && (((busWord ^ cmpVal[gi]) & cmpCare[gi]) == '0);
  end

  assign matchA = unitMatch[0];
  assign matchB = unitMatch[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeSel  <= MODE_OFF;
      coastSel <= '0;
      coastN   <= '0;
    end else if (cfgWrEn && cfgAddr == REG_CTRL) begin
      modeSel  <= cfgData[2:0];
      coastSel <= cfgData[6:4];
      coastN   <= cfgData[CNT_LSB +: CNT_W];
    end
  end

  always_comb begin
    unique case (coastSel)
      COAST_HIT_A:  coastEv = matchA;
      COAST_HIT_B:  coastEv = matchB;
      COAST_HIT_AB: coastEv = matchA | matchB;
      COAST_MEM:    coastEv = busValid & isMem;
      COAST_IO:     coastEv = busValid & isIo;
      COAST_MEMIO:  coastEv = busValid & (isMem | isIo);
      default:      coastEv = 1'b0;
    endcase
  end

  assign coastOn = (coastSel != 3'd0) && (coastSel != 3'd7) && (coastN != '0);
  assign cntLast = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hitA <= 1'b0;
      hitB <= 1'b0;
    end else begin
      hitA <= matchA;
      hitB <= matchB;
      if (strobe.loadCnt)     cnt <= coastN;
      else if (strobe.decCnt) cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/brk_control.sv
module brk_control
  import brk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWrEn,
  input  logic       haltClr,
  input  logic       matchA,
  input  logic       matchB,
  input  logic       coastEv,
  input  logic       coastOn,
  input  logic       cntLast,
  input  logic [2:0] modeSel,
  output ctlStrobe_t strobe,
  output logic       haltReq
);
  trigState_t state;
  logic armed;
  logic trig;
  logic armSrc;
  logic quiet;

  always_comb begin
    unique case (modeSel)
      MODE_A:       begin trig = matchA;           armSrc = 1'b0;   end
      MODE_B:       begin trig = matchB;           armSrc = 1'b0;   end
      MODE_EITHER:  begin trig = matchA | matchB;  armSrc = 1'b0;   end
      MODE_A_AFT_B: begin trig = matchA & armed;   armSrc = matchB; end
      MODE_B_AFT_A: begin trig = matchB & armed;   armSrc = matchA; end
      default:      begin trig = 1'b0;             armSrc = 1'b0;   end
    endcase
  end

  assign quiet          = !haltClr && !cfgWrEn;
  assign strobe.loadCnt = quiet && state == ST_WATCH && trig && coastOn;
  assign strobe.decCnt  = quiet && state == ST_COAST && coastEv && !cntLast;
  assign haltReq        = (state == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_WATCH;
      armed <= 1'b0;
    end else if (haltClr) begin
      state <= ST_WATCH;
      armed <= 1'b0;
    end else if (cfgWrEn) begin
      armed <= 1'b0;
      if (state == ST_COAST) state <= ST_WATCH;
    end else begin
      unique case (state)
        ST_WATCH: begin
          if (trig) begin
            armed <= 1'b0;
            state <= coastOn ? ST_COAST : ST_HALT;
          end else if (armSrc) begin
            armed <= 1'b1;
          end
        end
        ST_COAST: if (coastEv && cntLast) state <= ST_HALT;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/brk_trigger_top.sv
module brk_trigger_top
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STAT_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfgWrEn,
  input  logic [2:0]                 cfgAddr,
  input  logic [ADDR_W+2*STAT_W-1:0] cfgData,
  input  logic                       busValid,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [STAT_W-1:0]          cpuStat,
  input  logic [STAT_W-1:0]          userStat,
  input  logic                       isMem,
  input  logic                       isIo,
  input  logic                       haltClr,
  output logic                       hitA,
  output logic                       hitB,
  output logic                       haltReq
);
  ctlStrobe_t strobe;
  logic matchA, matchB, coastEv, coastOn, cntLast;
  logic [2:0] modeW;

  brk_datapath #(.ADDR_W(ADDR_W), .STAT_W(STAT_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .busValid(busValid), .busAddr(busAddr), .cpuStat(cpuStat), .userStat(userStat),
    .isMem(isMem), .isIo(isIo), .strobe(strobe), .matchA(matchA), .matchB(matchB),
    .coastEv(coastEv), .coastOn(coastOn), .cntLast(cntLast), .modeSel(modeW),
    .hitA(hitA), .hitB(hitB)
  );

  brk_control uCtl (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .haltClr(haltClr),
    .matchA(matchA), .matchB(matchB), .coastEv(coastEv), .coastOn(coastOn),
    .cntLast(cntLast), .modeSel(modeW), .strobe(strobe), .haltReq(haltReq)
  );
endmodule

// File: rtl/brk_checker.sv
module brk_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busValid,
  input logic       cfgWrEn,
  input logic       haltClr,
  input logic       hitA,
  input logic       hitB,
  input logic       haltReq,
  input logic [2:0] modeCur
);
  assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hitA || hitB) |-> $past(busValid));

  assert_halt_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (haltReq && !haltClr) |=> haltReq);

  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    haltClr |=> !haltReq);

  assert_cfg_blocks_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && !haltReq) |=> !haltReq);

  assert_halt_from_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(haltReq) |-> $past(busValid));

  assert_off_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(haltReq) |-> ($past(modeCur) < 3'd5));
endmodule

bind brk_trigger_top brk_checker uChk (
  .clk(clk), .rst_n(rst_n), .busValid(busValid), .cfgWrEn(cfgWrEn), .haltClr(haltClr),
  .hitA(hitA), .hitB(hitB), .haltReq(haltReq), .modeCur(modeW)
);

// File: tb/sim_brk_trigger_top.sv
module sim_brk_trigger_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic busValid = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0] cpuStat = '0, userStat = '0;
  logic isMem = 1'b0, isIo = 1'b0, haltClr = 1'b0;
  logic hitA, hitB, haltReq;

  int errors = 0;
  int checks = 0;
  string curReq = "R10";

  // reference model state
  logic [31:0] mVal [2];
  logic [31:0] mCare [2];
  logic [2:0] mMode = 3'd7, mCoast = 3'd0;
  logic [7:0] mN = '0, mCnt = '0;
  int mSt = 0;
  logic mArmed = 1'b0;
  logic eHitA = 1'b0, eHitB = 1'b0;

  always #4 clk = ~clk;

  brk_trigger_top u0 (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .busValid(busValid), .busAddr(busAddr), .cpuStat(cpuStat), .userStat(userStat),
    .isMem(isMem), .isIo(isIo), .haltClr(haltClr), .hitA(hitA), .hitB(hitB), .haltReq(haltReq)
  );

  function automatic logic wordMatch(input logic [31:0] w, input logic [31:0] v, input logic [31:0] c);
    return ((w ^ v) & c) == 32'd0;
  endfunction

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic doCycle(input logic v, input logic [15:0] a, input logic [7:0] cs, input logic [7:0] us,
                         input logic mem, input logic io, input logic clr, input logic wr,
                         input logic [2:0] wa, input logic [31:0] wd);
    logic [31:0] w;
    logic mA, mB, trig, armS, cOn, ev;
    @(negedge clk);
    busValid = v; busAddr = a; cpuStat = cs; userStat = us; isMem = mem; isIo = io;
    haltClr = clr; cfgWrEn = wr; cfgAddr = wa; cfgData = wd;
    w  = {a, cs, us};
    mA = v && wordMatch(w, mVal[0], mCare[0]);
    mB = v && wordMatch(w, mVal[1], mCare[1]);
    eHitA = mA; eHitB = mB;
    case (mMode)
      3'd0: begin trig = mA; armS = 1'b0; end
      3'd1: begin trig = mB; armS = 1'b0; end
      3'd2: begin trig = mA | mB; armS = 1'b0; end
      3'd3: begin trig = mA & mArmed; armS = mB; end
      3'd4: begin trig = mB & mArmed; armS = mA; end
      default: begin trig = 1'b0; armS = 1'b0; end
    endcase
    cOn = (mCoast >= 3'd1) && (mCoast <= 3'd6) && (mN != 8'd0);
    case (mCoast)
      3'd1: ev = mA;
      3'd2: ev = mB;
      3'd3: ev = mA | mB;
      3'd4: ev = v & mem;
      3'd5: ev = v & io;
      3'd6: ev = v & (mem | io);
      default: ev = 1'b0;
    endcase
    if (clr) begin
      mSt = 0; mArmed = 1'b0;
    end else if (wr) begin
      mArmed = 1'b0;
      if (mSt == 1) mSt = 0;
      case (wa)
        3'd0: mVal[0] = wd;
        3'd1: mCare[0] = wd;
        3'd2: mVal[1] = wd;
        3'd3: mCare[1] = wd;
        3'd4: begin mMode = wd[2:0]; mCoast = wd[6:4]; mN = wd[15:8]; end
        default: ;
      endcase
    end else if (mSt == 0) begin
      if (trig) begin
        mArmed = 1'b0;
        if (cOn) begin mSt = 1; mCnt = mN; end
        else mSt = 2;
      end else if (armS) mArmed = 1'b1;
    end else if (mSt == 1 && ev) begin
      if (mCnt == 8'd1) mSt = 2;
      else mCnt = mCnt - 8'd1;
    end
    @(posedge clk);
    #2;
    chk(curReq, "hitA", hitA, eHitA);
    chk(curReq, "hitB", hitB, eHitB);
    chk(curReq, "haltReq", haltReq, mSt == 2);
  endtask

  task automatic bus(input logic [15:0] a, input logic [7:0] cs, input logic mem, input logic io);
    doCycle(1'b1, a, cs, 8'h00, mem, io, 1'b0, 1'b0, 3'd0, 32'd0);
  endtask
  task automatic idle();
    doCycle(1'b0, 16'h0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
  endtask
  task automatic cfg(input logic [2:0] wa, input logic [31:0] wd);
    doCycle(1'b0, 16'h0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1, wa, wd);
  endtask
  task automatic clear();
    doCycle(1'b0, 16'h0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 32'd0);
  endtask
  function automatic logic [31:0] ctl(input int mode, input int kind, input int n);
    return {16'd0, 8'(n), 1'b0, 3'(kind), 1'b0, 3'(mode)};
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mVal[0] = '0; mVal[1] = '0; mCare[0] = '0; mCare[1] = '0;
    repeat (3) @(posedge clk);
    #2;
    curReq = "R10";
    chk(curReq, "hitA", hitA, 1'b0);
    chk(curReq, "haltReq", haltReq, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R3: after reset, masks are zero so every valid cycle hits, yet mode 7 never halts
    curReq = "R3";
    bus(16'h5555, 8'h12, 1'b1, 1'b0);
    bus(16'hAAAA, 8'h34, 1'b0, 1'b1);
    idle();

    // R1: A keyed on the address, B keyed on the CPU status byte
    curReq = "R1";
    cfg(3'd0, 32'h1234_0000); cfg(3'd1, 32'hFFFF_0000);
    cfg(3'd2, 32'h0000_A500); cfg(3'd3, 32'h0000_FF00);
    bus(16'h1234, 8'h00, 1'b0, 1'b0);
    bus(16'h1235, 8'hA5, 1'b0, 1'b0);
    bus(16'h1234, 8'hA5, 1'b0, 1'b0);
    // R2: an invalid cycle with a matching word gives no hit
    curReq = "R2";
    doCycle(1'b0, 16'h1234, 8'hA5, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);

    // R4: mode A with no coast
    curReq = "R4";
    cfg(3'd4, ctl(0, 0, 0));
    bus(16'h0000, 8'hA5, 1'b0, 1'b0);
    bus(16'h1234, 8'h00, 1'b0, 1'b0);
    // R8: level holds while halted and bus hits are ignored, then the clear drops it
    curReq = "R8";
    bus(16'h1234, 8'h00, 1'b0, 1'b0);
    idle();
    clear();
    idle();

    // R5: B after A; a cycle hitting both only arms it
    curReq = "R5";
    cfg(3'd4, ctl(4, 0, 0));
    bus(16'h1234, 8'hA5, 1'b0, 1'b0);
    bus(16'h1234, 8'h00, 1'b0, 1'b0);
    bus(16'h0000, 8'hA5, 1'b0, 1'b0);
    clear();
    // R5: A after B, trigger on A alone without arming must not halt
    cfg(3'd4, ctl(3, 0, 0));
    bus(16'h1234, 8'h00, 1'b0, 1'b0);
    bus(16'h0000, 8'hA5, 1'b0, 1'b0);
    bus(16'h1234, 8'h00, 1'b0, 1'b0);
    clear();

    // R6: coast over 3 memory cycles after the A trigger
    curReq = "R6";
    cfg(3'd4, ctl(0, 4, 3));
    bus(16'h1234, 8'h00, 1'b1, 1'b0);
    bus(16'h0001, 8'h00, 1'b1, 1'b0);
    bus(16'h0002, 8'h00, 1'b0, 1'b1);
    doCycle(1'b0, 16'h3, 8'h0, 8'h0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0);
    bus(16'h0004, 8'h00, 1'b1, 1'b0);
    bus(16'h0005, 8'h00, 1'b1, 1'b0);
    clear();
    // R6: coast over 2 B hits
    cfg(3'd4, ctl(2, 2, 2));
    bus(16'h1234, 8'hA5, 1'b0, 1'b0);
    bus(16'h0000, 8'hA5, 1'b0, 1'b0);
    bus(16'h1234, 8'h00, 1'b0, 1'b0);
    bus(16'h0000, 8'hA5, 1'b0, 1'b0);
    clear();

    // R7: n = 0 halts immediately
    curReq = "R7";
    cfg(3'd4, ctl(0, 4, 0));
    bus(16'h1234, 8'h00, 1'b1, 1'b0);
    clear();
    cfg(3'd4, ctl(1, 7, 5));
    bus(16'h0000, 8'hA5, 1'b0, 1'b0);
    clear();

    // R9: a write abandons a coast, and a write with a trigger cycle does not halt
    curReq = "R9";
    cfg(3'd4, ctl(0, 5, 1));
    bus(16'h1234, 8'h00, 1'b0, 1'b0);
    cfg(3'd0, 32'h1234_0000);
    bus(16'h0009, 8'h00, 1'b0, 1'b1);
    doCycle(1'b1, 16'h1234, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, ctl(0, 0, 0));
    idle();
    // R9: armed state cleared by a write
    cfg(3'd4, ctl(4, 0, 0));
    bus(16'h1234, 8'h00, 1'b0, 1'b0);
    cfg(3'd2, 32'h0000_A500);
    bus(16'h0000, 8'hA5, 1'b0, 1'b0);
    idle();

    // mixed random phase
    curReq = "RND";
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [7:0] cs;
      int r;
      r  = $urandom_range(0, 99);
      a  = ($urandom_range(0, 2) == 0) ? 16'h1234 : 16'($urandom_range(0, 3));
      cs = ($urandom_range(0, 2) == 0) ? 8'hA5 : 8'($urandom_range(0, 255));
      if (r < 3)
        clear();
      else if (r < 7)
        doCycle($urandom_range(0, 1) == 1, a, cs, 8'($urandom), $urandom_range(0, 1) == 1,
                $urandom_range(0, 1) == 1, 1'b0, 1'b1, 3'd4,
                ctl($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 4)));
      else
        doCycle($urandom_range(0, 3) != 0, a, cs, 8'($urandom), $urandom_range(0, 1) == 1,
                $urandom_range(0, 1) == 1, 1'b0, 1'b0, 3'd0, 32'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule